// File: doc/BRIEF.md
# Recursive Two-Bit-Fold Squarer

This block returns the square of an unsigned operand without a multiplier or any lookup table. A fold takes the top two bits of the current operand and, according to their value, reduces it to a shorter operand N* and produces a difference term D such that N² = N*² + D. Each fold removes two bits. Repeating the fold until no bits remain turns the square into the sum of one difference term per step. With the default 16-bit operand there are eight terms, 32, 28, 24, 20, 16, 12, 8 and 4 bits wide. The sum of these terms is the 32-bit square.

A term comes from a four-way select of fixed bit patterns. Each pattern is made of the lower bits L, their one's complement ~L (an XOR against a mask), and constant bits. The block also reports, for each step, whether that step's term is zero. Operands enter through a valid/ready handshake. They pass through three register stages: operand capture, difference terms, then sum. Results leave through a second valid/ready handshake. A stalled output freezes the whole pipeline.

Top module: `sqr_gen`

## Requirements
- R1: For every operand v accepted on the input, `sq_o` presents v*v exactly, as an unsigned value of 2*WIDTH bits.
- R2: When `out_ready_i` is held high, the result for an operand is first shown with `out_valid_o` high after the third rising edge, counting the edge that accepts the operand. With `out_ready_i` held high, one operand is accepted per cycle with no gaps.
- R3: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `sq_o` and `zero_o` stay unchanged on every following edge.
- R4: `in_ready_o` is low exactly when `out_valid_o` is high and `out_ready_i` is low. An operand is taken only when `in_valid_i` and `in_ready_o` are both high, and data offered while `in_ready_o` is low is dropped. Each accepted operand gives exactly one result, and results come out in order of acceptance.
- R5: Bit k of `zero_o` is 1 exactly when field k is 00. The fold starts with the full operand. At step k the field is the top two bits of the current operand, which is WIDTH-2k bits wide. The next operand is the remaining lower bits when the field is 00 or 10, and their one's complement when the field is 01 or 11. Bit 0 therefore reflects operand bits [WIDTH-1:WIDTH-2].
- R6: While `rst_ni` is low, `out_valid_o`, `sq_o` and `zero_o` are zero and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand offered |
| in_ready_o | output | 1 | Operand will be taken this cycle |
| in_data_i | input | WIDTH | Unsigned operand |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| sq_o | output | 2*WIDTH | Square of the operand |
| zero_o | output | WIDTH/2 | Per-step zero-term flags, bit 0 is the first fold |

## Verification
Every one of the 65536 operands is streamed back to back with the consumer always ready. This applies all four fold cases at every step and in every combination, and it separates a wrong pattern in any single case or step from a correct one. The bench computes the zero flags from its own model of the fold. A second pass uses random input gaps and random consumer stalls, so any operand captured while the pipeline is blocked shows up as an extra or out-of-order result. Directed runs time the first valid result of a lone operand and hold a full pipeline under stall while junk data is offered at the input.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  localparam int unsigned SQ_IN_W    = 16;
  localparam int unsigned SQ_LATENCY = 3;  // capture, terms, sum
endpackage

// File: rtl/sqr_fold.sv
// One fold step on a W-bit operand held in an OW-bit vector.
module sqr_fold #(
  parameter int unsigned OW = 16,
  parameter int unsigned W  = 16
) (
  input  logic [OW-1:0]   op_i,
  output logic [OW-1:0]   rem_o,
  output logic [2*OW-1:0] diff_o,
  output logic            zero_o
);
  localparam int unsigned M  = W - 2;
  localparam int unsigned DW = 2 * OW;
  localparam logic [OW-1:0] LMASK = {OW{1'b1}} >> (OW - M);
  localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};

  logic [1:0]    sel;
  logic [OW-1:0] low, low_n;
  logic [DW-1:0] lo_x, lon_x;

  assign sel   = op_i[W-1:W-2];
  assign low   = op_i & LMASK;
  assign low_n = (op_i ^ LMASK) & LMASK;  // one's complement of the lower bits
  assign lo_x  = {{OW{1'b0}}, low};
  assign lon_x = {{OW{1'b0}}, low_n};

  always_comb begin
    unique case (sel)
      2'b00:   diff_o = '0;
      2'b10:   diff_o = (ONE << (2*M + 2)) | (lo_x << (M + 2));
      2'b01:   diff_o = (lo_x << (M + 2)) | (lon_x << 1) | ONE;
      default: diff_o = (ONE << (2*M + 3)) | (lo_x << (M + 3)) | (lon_x << 1) | ONE;
    endcase
  end

  assign rem_o  = sel[0] ? low_n : low;
  assign zero_o = ~|diff_o;
endmodule

// File: rtl/sqr_sum.sv
module sqr_sum #(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 8
) (
  input  logic [N-1:0][DW-1:0] terms_i,
  output logic [DW-1:0]        sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) sum_o = sum_o + terms_i[i];
  end
endmodule

// File: rtl/sqr_gen.sv
module sqr_gen
  import sqr_pkg::*;
#(
  parameter int unsigned WIDTH = SQ_IN_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [WIDTH-1:0]     in_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [2*WIDTH-1:0]   sq_o,
  output logic [WIDTH/2-1:0]   zero_o
);
  localparam int unsigned STEPS = WIDTH / 2;
  localparam int unsigned DW    = 2 * WIDTH;

  logic                       adv;
  logic                       v1_q, v2_q;
  logic [WIDTH-1:0]           op_q;
  logic [STEPS-1:0][DW-1:0]   diff_c, diff_q;
  logic [STEPS-1:0]           zero_c, zero_q;
  logic [DW-1:0]              sum_c;
  logic [WIDTH-1:0]           fold_tail;

  assign adv        = ~out_valid_o | out_ready_i;
  assign in_ready_o = adv;

  for (genvar k = 0; k < STEPS; k++) begin : g_fold
    logic [WIDTH-1:0] op_in, rem;
    if (k == 0) begin : g_first
      assign op_in = op_q;
    end else begin : g_next
      assign op_in = g_fold[k-1].rem;
    end
    sqr_fold #(.OW(WIDTH), .W(WIDTH - 2*k)) u_fold (
      .op_i   (op_in),
      .rem_o  (rem),
      .diff_o (diff_c[k]),
      .zero_o (zero_c[k])
    );
  end

  assign fold_tail = g_fold[STEPS-1].rem;

  sqr_sum #(.DW(DW), .N(STEPS)) u_sum (
    .terms_i (diff_q),
    .sum_o   (sum_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      v2_q        <= 1'b0;
      out_valid_o <= 1'b0;
      op_q        <= '0;
      diff_q      <= '0;
      zero_q      <= '0;
      sq_o        <= '0;
      zero_o      <= '0;
    end else if (adv) begin
      v1_q        <= in_valid_i;
      v2_q        <= v1_q;
      out_valid_o <= v2_q;
      if (in_valid_i) op_q <= in_data_i;
      if (v1_q) begin
        diff_q <= diff_c;
        zero_q <= zero_c;
      end
      if (v2_q) begin
        sq_o   <= sum_c;
        zero_o <= zero_q;
      end
    end
  end
endmodule

// File: rtl/sqr_gen_chk.sv
module sqr_gen_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [2*WIDTH-1:0] sq_o,
  input logic [WIDTH/2-1:0] zero_o,
  input logic [WIDTH-1:0]   fold_tail
);
  logic [2:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else occ_q <= occ_q + 3'(in_valid_i && in_ready_o) - 3'(out_valid_o && out_ready_i);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R6: assert (!out_valid_o && in_ready_o && sq_o == '0 && zero_o == '0)
        else $error("reset state wrong");
    end
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(sq_o) && $stable(zero_o))
    else $error("result changed under stall");

  assert_square_bit1_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sq_o[1] == 1'b0)
    else $error("result cannot be a square");

  assert_fold_drained_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_tail == '0)
    else $error("fold left residue");

  assert_top_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> zero_o[0] == (sq_o[2*WIDTH-1 -: 4] == 4'd0))
    else $error("first flag disagrees with result range");

  assert_occupancy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= 3'd3 && (!out_valid_o || occ_q != 3'd0))
    else $error("operand/result count mismatch");
endmodule

bind sqr_gen sqr_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .sq_o        (sq_o),
  .zero_o      (zero_o),
  .fold_tail   (fold_tail)
);

// File: tb/sim_sqr_gen.sv
module sim_sqr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_data;
  logic [31:0] sq;
  logic [7:0]  zf;

  int checks = 0, fails = 0, out_cnt = 0, stall_cnt = 0;
  logic [15:0] fifo [0:65535];
  logic [15:0] wr_ptr = '0, rd_ptr = '0;
  int pend = 0;

  always #10 clk = ~clk;

  sqr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .sq_o(sq), .zero_o(zf)
  );

  function automatic logic [31:0] ref_sq(input logic [15:0] v);
    return {16'd0, v} * {16'd0, v};
  endfunction

  function automatic logic [7:0] ref_flags(input logic [15:0] v);
    int op = int'(v);
    logic [7:0] f = '0;
    for (int k = 0; k < 8; k++) begin
      int w = 16 - 2*k;
      int fld = (op >> (w - 2)) & 3;
      int msk = (1 << (w - 2)) - 1;
      f[k] = (fld == 0);
      op = (fld & 1) ? (~op & msk) : (op & msk);
    end
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard: record accepted operands, compare delivered results
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) begin
        fifo[wr_ptr] = in_data;
        wr_ptr = wr_ptr + 16'd1;
        pend++;
      end
      if (out_valid && out_ready) begin
        out_cnt++;
        if (pend == 0) chk(1'b0, "R4", "result without operand", sq, 32'd0);
        else begin
          chk(sq == ref_sq(fifo[rd_ptr]), "R1", "square", sq, ref_sq(fifo[rd_ptr]));
          chk(zf == ref_flags(fifo[rd_ptr]), "R5", "zero flags", {24'd0, zf},
              {24'd0, ref_flags(fifo[rd_ptr])});
          rd_ptr = rd_ptr + 16'd1;
          pend--;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] held_sq;
    logic [7:0]  held_zf;
    int base;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready && sq == 0 && zf == 0, "R6", "reset outputs",
        {out_valid, in_ready, 22'd0, zf}, {1'b0, 1'b1, 30'd0});
    @(posedge clk); #2 rst_n = 1'b1;

    // R2 latency of a lone operand
    @(posedge clk); #2 in_valid = 1'b1; in_data = 16'hBEEF;
    @(posedge clk); #2 in_valid = 1'b0;
    @(negedge clk); chk(!out_valid, "R2", "valid after edge 1", {31'd0, out_valid}, 32'd0);
    @(negedge clk); chk(!out_valid, "R2", "valid after edge 2", {31'd0, out_valid}, 32'd0);
    @(negedge clk); chk(out_valid, "R2", "valid after edge 3", {31'd0, out_valid}, 32'd1);
    @(negedge clk); chk(!out_valid, "R2", "single result only", {31'd0, out_valid}, 32'd0);

    // R1 R5 exhaustive stream, R2 throughput
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk); #2 in_valid = 1'b1; in_data = 16'(v);
      @(negedge clk); if (!in_ready) stall_cnt++;
    end
    @(posedge clk); #2 in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(stall_cnt == 0, "R2", "gaps in stream", 32'(stall_cnt), 32'd0);
    chk(out_cnt == 65537, "R4", "result count after sweep", 32'(out_cnt), 32'd65537);

    // R3 R4 stall with junk offered
    @(posedge clk); #2 out_ready = 1'b0; in_valid = 1'b1; in_data = 16'hFFFF;
    @(posedge clk); #2 in_data = 16'h4000;
    @(posedge clk); #2 in_data = 16'h3FFF;
    @(posedge clk); #2 in_data = 16'hC000;
    @(negedge clk);
    held_sq = sq; held_zf = zf;
    chk(out_valid && sq == ref_sq(16'hFFFF), "R3", "stalled head", sq, ref_sq(16'hFFFF));
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2 in_data = 16'(16'h1234 + i);
      @(negedge clk);
      chk(!in_ready, "R4", "ready under stall", {31'd0, in_ready}, 32'd0);
      chk(out_valid && sq == held_sq && zf == held_zf, "R3", "held result", sq, held_sq);
    end
    base = out_cnt;
    @(posedge clk); #2 in_valid = 1'b0; out_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(out_cnt - base == 3, "R4", "junk dropped", 32'(out_cnt - base), 32'd3);

    // R3 R4 random gaps and stalls
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2
      in_valid  = ($urandom % 3) != 0;
      in_data   = 16'($urandom);
      out_ready = ($urandom % 4) != 0;
    end
    @(posedge clk); #2 in_valid = 1'b0; out_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(pend == 0 && !out_valid, "R4", "drained", 32'(pend), 32'd0);
    finish_run();
  end
endmodule